// File: doc/BRIEF.md
# DMA Channel Address and Count Engine

This block is the per-transfer datapath of a single DMA channel. Software (through a register front end that lies outside this block) programs a starting address, a count, an 8-bit page value and two mode bits, then pulses a load strobe. From then on the engine presents a 24-bit memory byte address for the current transfer. Each time the request/acknowledge logic reports a finished transfer, the engine steps the address forward and counts the count down.

The count is programmed as the number of units minus one. When a transfer finds the count at zero, the count wraps to all ones. That is the terminal count. The engine then emits a one-cycle pulse and sets a sticky done flag. In single-run mode the channel then goes idle. In auto-initialise mode it reloads its start values and keeps running. The page value is never modified. A build-time parameter selects byte units or 16-bit word units. In word units the page's top seven bits, the 16-bit word address and a zero lsb form the byte address, which doubles the reach of one run to 128 KB. A channel loaded in cascade mode produces no addresses. It belongs to an external bus master.

Top module: `dma_addr_engine`

## Requirements
- R1: After synchronous reset, `addr_valid_o`, `tc_o` and `done_o` are 0 and `addr_o` is 0.
- R2: After a cycle with `load_i` high in non-cascade mode, the next cycle shows `addr_valid_o`=1, `done_o`=0 and `addr_o` formed from the loaded start address and page.
- R3: Each accepted transfer (`xfer_done_i` high while `addr_valid_o` is high and `load_i` is low) advances the current address by one unit. That is +1 byte in byte mode and +2 bytes in word mode.
- R4: With a programmed count N, exactly N+1 transfers take place. `tc_o` is high for exactly the one cycle after the transfer that found the count at zero, and at no other time.
- R5: Without auto-initialise, terminal count drops `addr_valid_o` and drives `addr_o` to 0. It also sets `done_o`, which stays set until the next load. Later `xfer_done_i` pulses are ignored.
- R6: With auto-initialise (`auto_init_i`=1 at load), terminal count reloads the current address and count from the loaded start values and keeps `addr_valid_o` high. `done_o` is set as well.
- R7: The address wraps from 0xFFFF to 0x0000 within its 16 bits. The page bits of `addr_o` never change during a run.
- R8: In word mode (`WORD_MODE`=1), `addr_o` = {page[7:1], word address[15:0], 1'b0}. Page bit 0 has no effect. In byte mode, `addr_o` = {page[7:0], address[15:0]}.
- R9: A load with `cascade_i`=1 leaves `addr_valid_o` low and `addr_o` at 0. Transfer pulses then cause no terminal count and no done flag.
- R10: When `load_i` and `xfer_done_i` are high in the same cycle, the load wins. No step takes place and `tc_o` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| load_i | input | 1 | Strobe: capture start address, count, page and mode |
| start_addr_i | input | 16 | Start address in units (bytes or words) |
| start_count_i | input | 16 | Number of units minus one |
| page_i | input | 8 | Fixed upper address byte |
| auto_init_i | input | 1 | Mode: reload at terminal count |
| cascade_i | input | 1 | Mode: channel owned by an external master |
| xfer_done_i | input | 1 | Strobe: one transfer acknowledged and completed |
| addr_o | output | 24 | Byte address of the current transfer |
| addr_valid_o | output | 1 | Channel is running and `addr_o` is meaningful |
| tc_o | output | 1 | One-cycle terminal-count pulse |
| done_o | output | 1 | Sticky terminal-count flag, cleared by load |

## Verification
A byte-mode and a word-mode engine run side by side on the same stimulus, and a scoreboard compares every presented address with both expected forms. The stimulus covers a short single run, which separates the N+1 transfer count from an off-by-one. A run straddling 0xFFFF shows whether a carry leaks into the page. A page with bit 0 set exposes a word-mode former that keeps that bit. Auto-initialise runs show reload against stopping, cascade loads show quiet against active, and a load coinciding with a transfer shows the priority between them. A zero count and pulses sent to an idle channel cover the boundary cases.

// File: rtl/dma_eng_pkg.sv
package dma_eng_pkg;
  typedef struct packed {
    logic auto_init;
    logic cascade;
  } dma_mode_t;
endpackage

// File: rtl/dma_base_regs.sv
module dma_base_regs
  import dma_eng_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int CNT_W  = 16,
  parameter int PAGE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ld_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [CNT_W-1:0]  cnt_i,
  input  logic [PAGE_W-1:0] page_i,
  input  dma_mode_t         mode_i,
  output logic [ADDR_W-1:0] base_addr_q,
  output logic [CNT_W-1:0]  base_cnt_q,
  output logic [PAGE_W-1:0] page_q,
  output dma_mode_t         mode_q
);
  // Start values held for the whole run; page is never touched by the datapath
  always_ff @(posedge clk) begin
    if (rst) begin
      base_addr_q <= '0;
      base_cnt_q  <= '0;
      page_q      <= '0;
      mode_q      <= '0;
    end else if (ld_i) begin
      base_addr_q <= addr_i;
      base_cnt_q  <= cnt_i;
      page_q      <= page_i;
      mode_q      <= mode_i;
    end
  end

  // R7: the page only moves on a load
  p_page_hold_r7: assert property (@(posedge clk) disable iff (rst)
    !ld_i |=> page_q == $past(page_q));
endmodule

// File: rtl/dma_cur_counter.sv
module dma_cur_counter #(
  parameter int ADDR_W = 16,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ld_i,
  input  logic [ADDR_W-1:0] ld_addr_i,
  input  logic [CNT_W-1:0]  ld_cnt_i,
  input  logic [ADDR_W-1:0] base_addr_i,
  input  logic [CNT_W-1:0]  base_cnt_i,
  input  logic              auto_i,
  input  logic              step_i,
  output logic [ADDR_W-1:0] cur_addr_o,
  output logic              wrap_o
);
  logic [ADDR_W-1:0] addr_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              cnt_zero;

  assign cnt_zero   = (cnt_q == '0);
  assign wrap_o     = step_i && !ld_i && cnt_zero;
  assign cur_addr_o = addr_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_q <= '0;
      cnt_q  <= '0;
    end else if (ld_i) begin
      addr_q <= ld_addr_i;
      cnt_q  <= ld_cnt_i;
    end else if (step_i) begin
      if (cnt_zero && auto_i) begin
        addr_q <= base_addr_i;
        cnt_q  <= base_cnt_i;
      end else begin
        addr_q <= addr_q + 1'b1;   // 16-bit wrap, no carry out
        cnt_q  <= cnt_q - 1'b1;    // zero wraps to all ones
      end
    end
  end

  // R3: ordinary step moves address up and count down by one
  p_step_advance_r3: assert property (@(posedge clk) disable iff (rst)
    step_i && !ld_i && !cnt_zero |=>
      addr_q == ADDR_W'($past(addr_q) + 1'b1) && cnt_q == CNT_W'($past(cnt_q) - 1'b1));

  // R6: auto-initialise reload at terminal count
  p_auto_reload_r6: assert property (@(posedge clk) disable iff (rst)
    step_i && !ld_i && cnt_zero && auto_i |=>
      addr_q == $past(base_addr_i) && cnt_q == $past(base_cnt_i));

  // R10: load takes priority over a step
  p_load_wins_cnt_r10: assert property (@(posedge clk) disable iff (rst)
    ld_i |=> addr_q == $past(ld_addr_i) && cnt_q == $past(ld_cnt_i));
endmodule

// File: rtl/dma_addr_form.sv
module dma_addr_form #(
  parameter bit WORD_MODE = 1'b0,
  parameter int ADDR_W    = 16,
  parameter int PAGE_W    = 8,
  localparam int OUT_W    = PAGE_W + ADDR_W
) (
  input  logic [PAGE_W-1:0] page_i,
  input  logic [ADDR_W-1:0] unit_addr_i,
  output logic [OUT_W-1:0]  byte_addr_o
);
  generate
    if (WORD_MODE) begin : g_word
      logic unused_page_lsb;
      assign unused_page_lsb = page_i[0];
      assign byte_addr_o = {page_i[PAGE_W-1:1], unit_addr_i, 1'b0};
    end else begin : g_byte
      assign byte_addr_o = {page_i, unit_addr_i};
    end
  endgenerate
endmodule

// File: rtl/dma_addr_engine.sv
module dma_addr_engine
  import dma_eng_pkg::*;
#(
  parameter bit WORD_MODE = 1'b0,
  parameter int ADDR_W    = 16,
  parameter int CNT_W     = 16,
  parameter int PAGE_W    = 8,
  localparam int OUT_W    = PAGE_W + ADDR_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load_i,
  input  logic [ADDR_W-1:0] start_addr_i,
  input  logic [CNT_W-1:0]  start_count_i,
  input  logic [PAGE_W-1:0] page_i,
  input  logic              auto_init_i,
  input  logic              cascade_i,
  input  logic              xfer_done_i,
  output logic [OUT_W-1:0]  addr_o,
  output logic              addr_valid_o,
  output logic              tc_o,
  output logic              done_o
);
  dma_mode_t         mode_in, mode_q;
  logic [ADDR_W-1:0] base_addr_q, cur_addr;
  logic [CNT_W-1:0]  base_cnt_q;
  logic [PAGE_W-1:0] page_q;
  logic [OUT_W-1:0]  formed_addr;
  logic              active_q, done_q, tc_q;
  logic              accept, wrap;

  assign mode_in.auto_init = auto_init_i;
  assign mode_in.cascade   = cascade_i;
  assign accept = xfer_done_i && active_q && !load_i;

  dma_base_regs #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .PAGE_W(PAGE_W)) u_base (
    .clk(clk), .rst(rst), .ld_i(load_i),
    .addr_i(start_addr_i), .cnt_i(start_count_i), .page_i(page_i), .mode_i(mode_in),
    .base_addr_q(base_addr_q), .base_cnt_q(base_cnt_q), .page_q(page_q), .mode_q(mode_q)
  );

  dma_cur_counter #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_cur (
    .clk(clk), .rst(rst), .ld_i(load_i),
    .ld_addr_i(start_addr_i), .ld_cnt_i(start_count_i),
    .base_addr_i(base_addr_q), .base_cnt_i(base_cnt_q),
    .auto_i(mode_q.auto_init), .step_i(accept),
    .cur_addr_o(cur_addr), .wrap_o(wrap)
  );

  dma_addr_form #(.WORD_MODE(WORD_MODE), .ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_form (
    .page_i(page_q), .unit_addr_i(cur_addr), .byte_addr_o(formed_addr)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      active_q <= 1'b0;
      done_q   <= 1'b0;
      tc_q     <= 1'b0;
    end else begin
      tc_q <= 1'b0;
      if (load_i) begin
        active_q <= !cascade_i;
        done_q   <= 1'b0;
      end else if (wrap) begin
        tc_q   <= 1'b1;
        done_q <= 1'b1;
        if (!mode_q.auto_init) active_q <= 1'b0;
      end
    end
  end

  assign addr_o       = active_q ? formed_addr : '0;
  assign addr_valid_o = active_q;
  assign tc_o         = tc_q;
  assign done_o       = done_q;

  // R4: a terminal-count pulse follows an accepted transfer
  p_tc_after_xfer_r4: assert property (@(posedge clk) disable iff (rst)
    tc_o |-> $past(xfer_done_i) && $past(active_q) && !$past(load_i));

  // R5: single-run terminal count leaves the channel idle and done
  p_idle_after_tc_r5: assert property (@(posedge clk) disable iff (rst)
    tc_o && !mode_q.auto_init |-> !addr_valid_o && done_o);

  // R5: done stays until a load
  p_done_sticky_r5: assert property (@(posedge clk) disable iff (rst)
    done_o && !load_i |=> done_o);

  // R9: a cascade channel never presents addresses
  p_cascade_quiet_r9: assert property (@(posedge clk) disable iff (rst)
    mode_q.cascade |-> !addr_valid_o && !tc_o);

  // R10: load in the same cycle as a transfer suppresses terminal count
  p_load_no_tc_r10: assert property (@(posedge clk) disable iff (rst)
    load_i |=> !tc_o);

  // R7: upper page bits of the output are fixed during a run
  p_page_fixed_r7: assert property (@(posedge clk) disable iff (rst)
    active_q && $past(active_q) && !$past(load_i) |->
      $stable(addr_o[OUT_W-1:ADDR_W+1]));
endmodule

// File: tb/dma_addr_engine_bench.sv
`timescale 1ns/1ps
module dma_addr_engine_bench;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic        rst, load, auto_m, casc, xfer;
  logic [15:0] b_addr, b_cnt;
  logic [7:0]  page;
  logic [23:0] a_addr, w_addr;
  logic        a_val, a_tc, a_done, w_val, w_tc, w_done;

  dma_addr_engine #(.WORD_MODE(1'b0)) u_dma_addr_engine (
    .clk(clk), .rst(rst), .load_i(load), .start_addr_i(b_addr), .start_count_i(b_cnt),
    .page_i(page), .auto_init_i(auto_m), .cascade_i(casc), .xfer_done_i(xfer),
    .addr_o(a_addr), .addr_valid_o(a_val), .tc_o(a_tc), .done_o(a_done));

  dma_addr_engine #(.WORD_MODE(1'b1)) u_dma_addr_engine_word (
    .clk(clk), .rst(rst), .load_i(load), .start_addr_i(b_addr), .start_count_i(b_cnt),
    .page_i(page), .auto_init_i(auto_m), .cascade_i(casc), .xfer_done_i(xfer),
    .addr_o(w_addr), .addr_valid_o(w_val), .tc_o(w_tc), .done_o(w_done));

  int n_cmp = 0, n_bad = 0;
  logic [47:0] sbq[$];

  // reference model state, written from the requirements
  logic [15:0] m_addr, m_cnt, m_base_addr, m_base_cnt;
  logic [7:0]  m_page;
  logic        m_auto, m_active, m_done;

  function automatic logic [23:0] exp_byte();
    return {m_page, m_addr};
  endfunction
  function automatic logic [23:0] exp_word();
    return {m_page[7:1], m_addr, 1'b0};
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // monitor: each transfer pops its expected address pair
  always @(negedge clk) begin
    if (!rst && xfer && !load && sbq.size() > 0) begin
      logic [47:0] it;
      it = sbq.pop_front();
      chk("R3 byte-mode address", {8'h0, a_addr}, {8'h0, it[23:0]});
      chk("R8 word-mode address", {8'h0, w_addr}, {8'h0, it[47:24]});
    end
  end

  task automatic do_load(input logic [15:0] a, input logic [15:0] c, input logic [7:0] p,
                         input logic au, input logic ca, input logic with_xfer);
    @(posedge clk); #1;
    load = 1'b1; b_addr = a; b_cnt = c; page = p; auto_m = au; casc = ca; xfer = with_xfer;
    @(posedge clk); #1;
    load = 1'b0; xfer = 1'b0;
    m_addr = a; m_cnt = c; m_base_addr = a; m_base_cnt = c; m_page = p;
    m_auto = au; m_active = !ca; m_done = 1'b0;
    chk("R2 valid after load", {31'h0, a_val}, {31'h0, m_active});
    chk("R2 done cleared", {31'h0, a_done}, 32'h0);
    chk("R2 byte address after load", {8'h0, a_addr}, m_active ? {8'h0, exp_byte()} : 32'h0);
    chk("R8 word address after load", {8'h0, w_addr}, m_active ? {8'h0, exp_word()} : 32'h0);
    chk("R10 no tc on load", {31'h0, a_tc}, 32'h0);
  endtask

  task automatic do_xfer(input string tg);
    logic exp_tc;
    exp_tc = 1'b0;
    @(posedge clk); #1;
    if (m_active) sbq.push_back({exp_word(), exp_byte()});
    xfer = 1'b1;
    @(posedge clk); #1;
    xfer = 1'b0;
    if (m_active) begin
      if (m_cnt == 16'h0) begin
        exp_tc = 1'b1; m_done = 1'b1;
        if (m_auto) begin m_addr = m_base_addr; m_cnt = m_base_cnt; end
        else m_active = 1'b0;
      end else begin
        m_addr = m_addr + 16'h1; m_cnt = m_cnt - 16'h1;
      end
    end
    chk({tg, " tc byte"}, {31'h0, a_tc}, {31'h0, exp_tc});
    chk({tg, " tc word"}, {31'h0, w_tc}, {31'h0, exp_tc});
    chk({tg, " valid"}, {31'h0, a_val}, {31'h0, m_active});
    chk({tg, " done"}, {31'h0, a_done}, {31'h0, m_done});
    if (!m_active) chk({tg, " idle address"}, {8'h0, a_addr}, 32'h0);
  endtask

  initial begin
    #(8 * 200000);
    n_bad++;
    $display("FAIL watchdog: actual running expected finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    rst = 1'b1; load = 1'b0; xfer = 1'b0; b_addr = '0; b_cnt = '0; page = '0;
    auto_m = 1'b0; casc = 1'b0;
    m_active = 1'b0; m_done = 1'b0;
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    @(posedge clk); #1;
    chk("R1 reset valid", {31'h0, a_val}, 32'h0);
    chk("R1 reset tc", {31'h0, a_tc}, 32'h0);
    chk("R1 reset done", {31'h0, a_done}, 32'h0);
    chk("R1 reset address", {8'h0, a_addr}, 32'h0);
    chk("R1 reset word valid", {31'h0, w_val}, 32'h0);

    // R4/R5: four transfers from count 3, then idle
    do_load(16'h1234, 16'd3, 8'h5A, 1'b0, 1'b0, 1'b0);
    for (int i = 0; i < 4; i++) do_xfer("R4 single run");
    do_xfer("R5 ignored after tc");
    chk("R5 word done", {31'h0, w_done}, 32'h1);

    // R7: wrap inside 16 bits, page bit0 set to exercise R8
    do_load(16'hFFFE, 16'd3, 8'h11, 1'b0, 1'b0, 1'b0);
    for (int i = 0; i < 4; i++) do_xfer("R7 wrap run");

    // R6: auto-initialise keeps running through two terminal counts
    do_load(16'h0100, 16'd1, 8'h3C, 1'b1, 1'b0, 1'b0);
    for (int i = 0; i < 5; i++) do_xfer("R6 auto run");

    // R9: cascade channel stays quiet
    do_load(16'h0800, 16'd0, 8'h77, 1'b0, 1'b1, 1'b0);
    do_xfer("R9 cascade");
    do_xfer("R9 cascade");
    chk("R9 word valid", {31'h0, w_val}, 32'h0);

    // R10: load with a simultaneous transfer, then count zero boundary (R4)
    do_load(16'h0040, 16'd0, 8'h01, 1'b0, 1'b0, 1'b0);
    do_load(16'h0200, 16'd2, 8'h22, 1'b0, 1'b0, 1'b1);
    for (int i = 0; i < 3; i++) do_xfer("R10 after priority load");
    do_load(16'h0300, 16'd0, 8'h44, 1'b0, 1'b0, 1'b0);
    do_xfer("R4 zero count");
    do_xfer("R5 idle after zero count");

    chk("R3 scoreboard drained", sbq.size(), 32'h0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule